// File: doc/BRIEF.md
# Sampled Transaction Performance Counters

This block measures bus activity over a window of programmed length. Software writes a duration, in clock cycles, to the window timer register. That write opens a sampling window at once. The timer then counts down by one every clock until it reaches zero, and the window stays open for exactly as many cycles as the value written.

While the window is open, each accepted success strobe adds one to one of eight 32-bit counters. A strobe is tagged with a bus side (near or far) and a transaction kind (I/O read, I/O write, memory read or memory write), and the tag selects the counter. When the timer reaches zero, the counters freeze and hold their values until software reads them. A nonzero write to the timer wipes every counter, so each window starts from zero.

The strobe input is a plain per-clock pulse. It has no ready signal and no back-pressure: the block takes one strobe in every cycle that `evt_valid` is high. The register port is also plain. A write takes effect at the next rising edge. A read is combinational on the address and needs no strobe.

Top module: `perf_sampler`

## Requirements
- R1: After reset, the timer register (byte address 0x7C) and all eight counters read zero.
- R2: A write to 0x7C loads the timer. The timer value reads back at 0x7C and drops by one at every clock edge while it is nonzero. At zero it stays at zero.
- R3: A strobe with `evt_side`=0 increments the counter at 0x80 + 4*kind. A strobe with `evt_side`=1 increments the counter at 0x90 + 4*kind. The kind codes are 0 = I/O read, 1 = I/O write, 2 = memory read and 3 = memory write. One strobe adds exactly one, and no other counter changes.
- R4: A strobe counts only in a cycle in which the timer is nonzero. A timer value of N therefore admits strobes during exactly the N cycles after the write. Strobes with the timer at zero leave every counter unchanged.
- R5: Writing a nonzero value to 0x7C clears all eight counters. Writing zero to 0x7C closes the window at once and leaves the counters as they were.
- R6: A counter at 0xFFFFFFFF stays at 0xFFFFFFFF when further strobes arrive.
- R7: Software can write any counter. When a software write and a strobe hit the same counter in the same clock, the written value is kept.
- R8: A read of an address that maps to no register returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address (used for both read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| evt_valid | input | 1 | Success strobe, taken in every cycle it is high |
| evt_side | input | 1 | Bus side of the strobe: 0 = far side, 1 = near side |
| evt_kind | input | 2 | Transaction kind: 0 I/O read, 1 I/O write, 2 memory read, 3 memory write |

## Verification
The main function is exercised with several strobe patterns:
- Bursts that end inside the window, which show that every strobe counts.
- Bursts that run past the end of the window, which show that counting stops exactly at the timer expiry.
- Strobes spaced one or two idle cycles apart, which separate "counting cycles" from "counting strobes".
- A one-cycle window, which exposes off-by-one errors at the start of the window.

Each pattern uses a different side and kind. All eight counters are read after every window, so a wrong counter choice shows up, and so does a missing clear from the previous window. Directed cases then cover:
- saturation at all ones;
- a software write landing in the same clock as a strobe;
- a write of zero that stops the window early;
- the timer's countdown as seen at its read-back address.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int NUM_SIDES = 2;
  localparam int NUM_KINDS = 4;
  localparam int NUM_CNT   = NUM_SIDES * NUM_KINDS;
  localparam int SIDE_W    = $clog2(NUM_SIDES);
  localparam int KIND_W    = $clog2(NUM_KINDS);

  typedef enum logic [KIND_W-1:0] {
    KIND_IO_RD  = 2'd0,
    KIND_IO_WR  = 2'd1,
    KIND_MEM_RD = 2'd2,
    KIND_MEM_WR = 2'd3
  } kind_e;

  localparam logic [7:0] TIMER_OFS   = 8'h7C;
  localparam logic [7:0] CNT_BASE    = 8'h80;
  localparam int         SIDE_STRIDE = NUM_KINDS * 4;

  function automatic logic [7:0] cnt_offset(input int idx);
    int side;
    int kind;
    side = idx / NUM_KINDS;
    kind = idx % NUM_KINDS;
    return CNT_BASE + 8'(side * SIDE_STRIDE) + 8'(kind * 4);
  endfunction
endpackage

// File: rtl/perf_window.sv
module perf_window #(
  parameter int TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TIMER_W-1:0] load_val,
  output logic [TIMER_W-1:0] timer_q,
  output logic               active,
  output logic               restart
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
    end else if (load) begin
      timer_q <= load_val;
    end else if (timer_q != '0) begin
      timer_q <= timer_q - 1'b1;
    end
  end

  assign active  = (timer_q != '0) && !load;
  assign restart = load && (load_val != '0);
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr) begin
      q <= wdata;
    end else if (clr) begin
      q <= '0;
    end else if (inc && (q != CNT_MAX)) begin
      q <= q + 1'b1;
    end
  end
endmodule

// File: rtl/perf_readmux.sv
module perf_readmux
  import perf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              timer_q,
  input  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_all,
  output logic [DATA_W-1:0]              rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(TIMER_OFS)) begin
      rdata = timer_q;
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr == ADDR_W'(cnt_offset(i))) begin
        rdata = cnt_all[i];
      end
    end
  end
endmodule

// File: rtl/perf_sampler.sv
module perf_sampler
  import perf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_valid,
  input  logic [SIDE_W-1:0] evt_side,
  input  logic [KIND_W-1:0] evt_kind
);
  logic                          timer_wr;
  logic [DATA_W-1:0]             timer_q;
  logic                          win_active;
  logic                          win_restart;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_all;

  assign timer_wr = reg_wr && (reg_addr == ADDR_W'(TIMER_OFS));

  perf_window #(.TIMER_W(DATA_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_wr),
    .load_val (reg_wdata),
    .timer_q  (timer_q),
    .active   (win_active),
    .restart  (win_restart)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [SIDE_W-1:0] MY_SIDE = SIDE_W'(i / NUM_KINDS);
    localparam logic [KIND_W-1:0] MY_KIND = KIND_W'(i % NUM_KINDS);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(cnt_offset(i));
    logic sel_wr;
    logic sel_inc;

    assign sel_wr  = reg_wr && (reg_addr == MY_ADDR);
    assign sel_inc = evt_valid && win_active &&
                     (evt_side == MY_SIDE) && (evt_kind == MY_KIND);

    perf_counter #(.CNT_W(DATA_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (sel_wr),
      .wdata (reg_wdata),
      .clr   (win_restart),
      .inc   (sel_inc),
      .q     (cnt_all[i])
    );
  end

  perf_readmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_readmux (
    .addr    (reg_addr),
    .timer_q (timer_q),
    .cnt_all (cnt_all),
    .rdata   (reg_rdata)
  );
endmodule

// File: rtl/perf_sampler_chk.sv
module perf_sampler_chk
  import perf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [DATA_W-1:0]             reg_wdata,
  input logic [DATA_W-1:0]             timer_q,
  input logic [NUM_CNT-1:0][DATA_W-1:0] cnt_all
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  logic t_wr;
  assign t_wr = reg_wr && (reg_addr == ADDR_W'(TIMER_OFS));

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!t_wr && timer_q != '0) |=> timer_q == $past(timer_q) - 1'b1); // R2
  AST_TIMER_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (!t_wr && timer_q == '0) |=> timer_q == '0); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_q == '0 && !reg_wr) |=> $stable(cnt_all)); // R4
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (t_wr && reg_wdata != '0) |=> cnt_all == '0); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_all[0] == ALL_ONES && !reg_wr) |=> cnt_all[0] == ALL_ONES); // R6
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && cnt_all[0] != ALL_ONES) |=>
      (cnt_all[0] == $past(cnt_all[0]) || cnt_all[0] == $past(cnt_all[0]) + 1'b1)); // R3
  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CNT_BASE)) |=> cnt_all[0] == $past(reg_wdata)); // R7
endmodule

bind perf_sampler perf_sampler_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .timer_q   (timer_q),
  .cnt_all   (cnt_all)
);

// File: tb/perf_sampler_tb.sv
module perf_sampler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        evt_valid = 1'b0;
  logic [0:0]  evt_side = '0;
  logic [1:0]  evt_kind = '0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  perf_sampler u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
    .evt_side(evt_side), .evt_kind(evt_kind)
  );

  typedef struct packed {
    logic [31:0] t;
    logic        side;
    logic [1:0]  kind;
    logic [31:0] n;
    logic [31:0] gap;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'd10, 1'b1, 2'd0, 32'd5,  32'd0},
    '{32'd10, 1'b0, 2'd1, 32'd15, 32'd0},
    '{32'd10, 1'b1, 2'd2, 32'd8,  32'd1},
    '{32'd1,  1'b0, 2'd3, 32'd3,  32'd0},
    '{32'd20, 1'b1, 2'd3, 32'd20, 32'd0},
    '{32'd7,  1'b0, 2'd2, 32'd4,  32'd2}
  };

  function automatic logic [7:0] addr_of(input int side, input int kind);
    return 8'h80 + 8'(side * 16) + 8'(kind * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_events(input int side, input int kind, input int n, input int gap);
    int span;
    span = (n - 1) * (gap + 1) + 1;
    for (int j = 0; j < span; j++) begin
      evt_valid = (j % (gap + 1) == 0);
      evt_side = 1'(side);
      evt_kind = 2'(kind);
      @(negedge clk);
    end
    evt_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(8'h7C, v);
      if (v == 0) break;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h7C, v); chk("R1 timer", v, 0);
    for (int i = 0; i < 8; i++) begin
      rd(addr_of(i / 4, i % 4), v);
      chk("R1 counter", v, 0);
    end
    // R8 unmapped address
    rd(8'h00, v); chk("R8 unmapped", v, 0);
    rd(8'hA0, v); chk("R8 unmapped", v, 0);

    // R2 timer countdown seen at read-back
    wr(8'h7C, 32'd100);
    rd(8'h7C, v); chk("R2 timer", v, 99);
    rd(8'h7C, v); chk("R2 timer", v, 98);
    wait_idle();
    rd(8'h7C, v); chk("R2 timer rests", v, 0);

    // table walk: R3 R4 R5
    for (int vi = 0; vi < NV; vi++) begin
      int exp_cnt;
      exp_cnt = 0;
      for (int k = 0; k < int'(VECS[vi].n); k++)
        if (k * (int'(VECS[vi].gap) + 1) < int'(VECS[vi].t)) exp_cnt++;
      wr(8'h7C, VECS[vi].t);
      pulse_events(VECS[vi].side, VECS[vi].kind, VECS[vi].n, VECS[vi].gap);
      wait_idle();
      for (int i = 0; i < 8; i++) begin
        int e;
        e = (i / 4 == int'(VECS[vi].side) && i % 4 == int'(VECS[vi].kind)) ? exp_cnt : 0;
        rd(addr_of(i / 4, i % 4), v);
        chk("R3 R4 R5 window count", v, 32'(e));
      end
    end

    // R4 strobes with the window closed do nothing (last counter 0x88 = 3)
    pulse_events(0, 2, 5, 0);
    rd(8'h88, v); chk("R4 idle strobes", v, 3);

    // R5 zero write stops window, keeps counts
    wr(8'h7C, 32'd50);
    pulse_events(0, 2, 4, 0);
    wr(8'h7C, 32'd0);
    pulse_events(0, 2, 3, 0);
    rd(8'h88, v); chk("R5 zero write keeps", v, 4);
    rd(8'h7C, v); chk("R5 zero write stops", v, 0);

    // R6 saturation
    wr(8'h7C, 32'd60);
    wr(8'h90, 32'hFFFF_FFFE);
    pulse_events(1, 0, 3, 0);
    rd(8'h90, v); chk("R6 saturate", v, 32'hFFFF_FFFF);

    // R7 software write beats a same-cycle strobe
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h84; reg_wdata = 32'h55;
    evt_valid = 1'b1; evt_side = 1'b0; evt_kind = 2'd1;
    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0;
    #1;
    chk("R7 write wins", reg_rdata, 32'h55);
    pulse_events(0, 1, 2, 0);
    rd(8'h84, v); chk("R7 then counts", v, 32'h57);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule